// File: doc/BRIEF.md
# Parked-Owner Bus Arbiter with Lookahead

This block decides which of several masters may drive a shared bus. Each master has its own request line, grant line and release line. A master raises its request, holds it until its grant appears, and only then starts using the bus. It raises its release line for one cycle after the last word of its transfer. The lowest-indexed requester always wins, so master 0 has the top priority.

The choice of the following owner is made while the current owner is still transferring. That choice is registered and shown on `next_owner_o`. When the owner releases, the grant moves to that registered winner on the same clock edge, so the bus never sits idle between tenures. If nobody else is waiting when the owner releases, the owner stays parked on the bus. It can begin another transfer by raising its request, without going through arbitration. It loses the parked grant as soon as another master is shown as the next owner.

The next-owner register samples the request lines once per cycle. A request therefore shows up on `next_owner_o` one cycle after it is presented. It can take the bus from an empty or parked state on the edge after that. Masters must keep their request asserted until they are granted.

Top module: `bus_arb_park`

## Requirements
- R1: After reset both `gnt_o` and `next_owner_o` are all zero, and they stay zero while no request is present.
- R2: At most one bit of `gnt_o` is ever set.
- R3: One cycle after a set of requests is presented, `next_owner_o` shows the lowest-indexed requester among them, leaving out the master that holds the grant in that cycle. It shows zero when no such requester exists.
- R4: When no master holds the bus and `next_owner_o` is non-zero, `gnt_o` equals `next_owner_o` after the next clock edge.
- R5: While a tenure is active, the grant is not withdrawn before the owner releases, even when a higher-priority master is requesting.
- R6: When the owner releases while `next_owner_o` is non-zero, `gnt_o` equals that `next_owner_o` value in the very next cycle, with no cycle that has no grant.
- R7: When the owner releases while `next_owner_o` is zero, the owner keeps its grant (parking).
- R8: A parked owner that raises its request while `next_owner_o` is zero begins a new tenure without any change in `gnt_o`. That tenure is then protected by R5.
- R9: A parked owner loses its grant to `next_owner_o` on the first edge at which `next_owner_o` is non-zero, even if that master has lower priority.
- R10: A release pulse from a master that does not hold the grant, or from a parked owner that is not in a tenure, leaves `gnt_o` unchanged.
- R11: On a release, the grant goes to the `next_owner_o` value shown in the release cycle. A request that first appears in that same cycle waits, even if it has higher priority. If no winner was shown, the owner parks and the late request takes over on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| req_i | input | NUM_MASTERS | Request line per master, held until granted |
| rel_i | input | NUM_MASTERS | Release pulse per master, raised after its last word |
| gnt_o | output | NUM_MASTERS | One-hot grant per master |
| next_owner_o | output | NUM_MASTERS | Registered one-hot winner for the next tenure, zero if none |

## Verification
The delicate case is a release landing in the same cycle as a fresh request. The lookahead register still holds the winner picked from the previous cycle's requests, so the newcomer cannot take part in that handover. The bench drives a release together with a new higher-priority request while a lower-priority winner is already shown, and expects the shown winner to get the grant. It also drives a release with no winner shown while a new request arrives, and expects the owner to park for one cycle before the newcomer takes over.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    ARB_EMPTY  = 2'd0,
    ARB_HELD   = 2'd1,
    ARB_PARKED = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] cand_i,
  output logic [WIDTH-1:0] win_o
);
  // Fixed priority: bit 0 beats every higher bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_top
      assign win_o[i] = cand_i[i];
    end else begin : g_rest
      assign win_o[i] = cand_i[i] & ~(|cand_i[i-1:0]);
    end
  end
endmodule

// File: rtl/arb_lookahead.sv
module arb_lookahead #(
  parameter int unsigned NUM_MASTERS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] gnt_nxt_i,
  output logic [NUM_MASTERS-1:0] nxt_o
);
  logic [NUM_MASTERS-1:0] contenders;
  logic [NUM_MASTERS-1:0] pick;
  logic [NUM_MASTERS-1:0] nxt_q;
  logic                   nxt_en;

  // The master about to hold the bus never competes for the next tenure.
  assign contenders = req_i & ~gnt_nxt_i;

  arb_prio_pick #(.WIDTH(NUM_MASTERS)) u_pick (
    .cand_i (contenders),
    .win_o  (pick)
  );

  assign nxt_en = (pick != nxt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
    end else if (nxt_en) begin
      nxt_q <= pick;
    end
  end

  assign nxt_o = nxt_q;

  p_next_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nxt_q));

  p_next_was_requesting_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|nxt_q) |-> ((nxt_q & $past(req_i)) != '0));
endmodule

// File: rtl/arb_tenure.sv
module arb_tenure
  import bus_arb_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] rel_i,
  input  logic [NUM_MASTERS-1:0] nxt_i,
  output logic [NUM_MASTERS-1:0] gnt_o,
  output logic [NUM_MASTERS-1:0] gnt_nxt_o
);
  arb_state_e             state_q, state_d;
  logic [NUM_MASTERS-1:0] gnt_q, gnt_d;
  logic                   owner_rel;
  logic                   have_cand;
  logic                   owner_req;
  logic                   gnt_en;
  logic                   state_en;

  assign owner_rel = |(rel_i & gnt_q);
  assign owner_req = |(req_i & gnt_q);
  assign have_cand = |nxt_i;

  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    unique case (state_q)
      ARB_EMPTY: begin
        if (have_cand) begin
          gnt_d   = nxt_i;
          state_d = ARB_HELD;
        end
      end
      ARB_HELD: begin
        if (owner_rel) begin
          if (have_cand) begin
            gnt_d = nxt_i;
          end else begin
            state_d = ARB_PARKED;
          end
        end
      end
      ARB_PARKED: begin
        if (have_cand) begin
          gnt_d   = nxt_i;
          state_d = ARB_HELD;
        end else if (owner_req) begin
          state_d = ARB_HELD;
        end
      end
      default: begin
        gnt_d   = '0;
        state_d = ARB_EMPTY;
      end
    endcase
  end

  assign gnt_en   = (gnt_d != gnt_q);
  assign state_en = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= '0;
    end else if (gnt_en) begin
      gnt_q <= gnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ARB_EMPTY;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_nxt_o = gnt_d;

  p_grant_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_q));

  p_empty_takes_winner_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_EMPTY && |nxt_i) |=> (gnt_q == $past(nxt_i)));

  p_tenure_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_HELD && (rel_i & gnt_q) == '0) |=> $stable(gnt_q));

  p_handover_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_HELD && |(rel_i & gnt_q) && |nxt_i) |=> (gnt_q == $past(nxt_i)));

  p_park_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_HELD && |(rel_i & gnt_q) && nxt_i == '0)
      |=> ($stable(gnt_q) && state_q == ARB_PARKED));

  p_parked_yields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARB_PARKED && |nxt_i) |=> (gnt_q == $past(nxt_i)));

  p_foreign_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ARB_EMPTY && nxt_i == '0 && (rel_i & gnt_q) == '0 && (req_i & gnt_q) == '0)
      |=> $stable(gnt_q));
endmodule

// File: rtl/bus_arb_park.sv
module bus_arb_park #(
  parameter int unsigned NUM_MASTERS = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] rel_i,
  output logic [NUM_MASTERS-1:0] gnt_o,
  output logic [NUM_MASTERS-1:0] next_owner_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic [NUM_MASTERS-1:0] gnt_nxt;
  logic [NUM_MASTERS-1:0] nxt;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  arb_lookahead #(.NUM_MASTERS(NUM_MASTERS)) u_look (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .req_i     (req_i),
    .gnt_nxt_i (gnt_nxt),
    .nxt_o     (nxt)
  );

  arb_tenure #(.NUM_MASTERS(NUM_MASTERS)) u_ten (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .req_i     (req_i),
    .rel_i     (rel_i),
    .nxt_i     (nxt),
    .gnt_o     (gnt_o),
    .gnt_nxt_o (gnt_nxt)
  );

  assign next_owner_o = nxt;

  p_idle_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ($past(gnt_o) == '0 && $past(req_i) == '0) |-> (next_owner_o == '0 && gnt_o == '0));
endmodule

// File: tb/tb_bus_arb_park.sv
module tb_bus_arb_park;
  localparam int NM = 4;

  typedef struct packed {
    logic [NM-1:0] g;
    logic [NM-1:0] n;
    int            rid;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NM-1:0] req, rel;
  logic [NM-1:0] gnt, nxt;

  exp_t q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  bus_arb_park #(.NUM_MASTERS(NM)) dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .rel_i        (rel),
    .gnt_o        (gnt),
    .next_owner_o (nxt)
  );

  // Driver: inputs for the coming edge, plus the outputs expected after it.
  task automatic step(input logic [NM-1:0] r, input logic [NM-1:0] l,
                      input logic [NM-1:0] eg, input logic [NM-1:0] en, input int rid);
    exp_t e;
    @(negedge clk);
    req = r;
    rel = l;
    e.g = eg; e.n = en; e.rid = rid;
    q.push_back(e);
  endtask

  // Monitor: compares just after each edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (gnt !== e.g) begin
        n_bad++;
        $display("FAIL R%0d gnt actual=%b expected=%b", e.rid, gnt, e.g);
      end
      n_cmp++;
      if (nxt !== e.n) begin
        n_bad++;
        $display("FAIL R%0d next_owner actual=%b expected=%b", e.rid, nxt, e.n);
      end
      n_cmp++;
      if ($countones(gnt) > 1) begin  // R2
        n_bad++;
        $display("FAIL R2 gnt actual=%b expected=at most one bit", gnt);
      end
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; rel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1);  // R1 idle after reset
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000, 1);  // R1
    step(4'b0100, 4'b0000, 4'b0000, 4'b0100, 3);  // R3 lone request shown
    step(4'b0100, 4'b0000, 4'b0100, 4'b0000, 4);  // R4 empty bus takes winner
    step(4'b0101, 4'b0000, 4'b0100, 4'b0001, 5);  // R5 higher priority waits
    step(4'b0111, 4'b0000, 4'b0100, 4'b0001, 3);  // R3 index 0 beats 1
    step(4'b0111, 4'b1000, 4'b0100, 4'b0001, 10); // R10 foreign release
    step(4'b0011, 4'b0100, 4'b0001, 4'b0010, 6);  // R6 zero-gap handover
    step(4'b0011, 4'b0000, 4'b0001, 4'b0010, 5);  // R5
    step(4'b0010, 4'b0001, 4'b0010, 4'b0000, 6);  // R6
    step(4'b0000, 4'b0010, 4'b0010, 4'b0000, 7);  // R7 park
    step(4'b0000, 4'b0000, 4'b0010, 4'b0000, 7);  // R7 stays parked
    step(4'b1000, 4'b0000, 4'b0010, 4'b1000, 9);  // R9 competitor shown
    step(4'b1000, 4'b0000, 4'b1000, 4'b0000, 9);  // R9 low priority takes parked bus
    step(4'b0000, 4'b1000, 4'b1000, 4'b0000, 7);  // R7
    step(4'b1000, 4'b0000, 4'b1000, 4'b0000, 8);  // R8 parked owner restarts
    step(4'b1001, 4'b0000, 4'b1000, 4'b0001, 8);  // R8 new tenure protected
    step(4'b0001, 4'b0000, 4'b1000, 4'b0001, 8);  // R8
    step(4'b0001, 4'b1000, 4'b0001, 4'b0000, 6);  // R6
    step(4'b0100, 4'b0000, 4'b0001, 4'b0100, 3);  // R3
    step(4'b0110, 4'b0001, 4'b0100, 4'b0010, 11); // R11 late higher request waits
    step(4'b0010, 4'b0000, 4'b0100, 4'b0010, 11); // R11
    step(4'b0010, 4'b0100, 4'b0010, 4'b0000, 6);  // R6
    step(4'b0001, 4'b0010, 4'b0010, 4'b0001, 11); // R11 no winner shown: park
    step(4'b0001, 4'b0000, 4'b0001, 4'b0000, 11); // R11 newcomer then takes over
    step(4'b0000, 4'b0001, 4'b0001, 4'b0000, 7);  // R7
    step(4'b0000, 4'b0001, 4'b0001, 4'b0000, 10); // R10 release while parked
    step(4'b0000, 4'b0000, 4'b0001, 4'b0000, 10); // R10
    @(negedge clk);
    req = '0; rel = '0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule